// File: doc/BRIEF.md
# Dual-Mode Floating-Point Register Bank

This block holds the floating-point architectural registers of a processor core. Every entry is stored 64 bits wide. A static width-mode input picks how double-precision values map onto the entries. In wide mode an entry holds one whole double. In narrow mode a double is split across an even/odd pair of entries: the low word sits in the low half of the even entry and the high word in the low half of the odd entry.

Software-visible moves are served by three access kinds. A low-word access reads or writes bits 31:0, and its write clears the upper half. A high-word access reads or writes bits 63:32. A double access follows the mode. The bank has a parameterised number of synchronous write ports and combinational read ports. When two write ports touch the same half of an entry in one cycle, the lower-numbered port wins that half.

These are plain register-file pins. There is no data stream and no back-pressure: a write is taken on the clock edge where its enable is high, and a read returns data in the same cycle. The width mode is expected to change only while reset is asserted.

Top module: `fpr_bank`

## Requirements
- R1: While reset is low, every entry becomes zero on the clock edge, in both modes.
- R2: A write of kind 0 (low word) puts wr_data bits 31:0 into bits 31:0 of the entry and clears bits 63:32. This holds in both modes.
- R3: A write of kind 1 (high word) puts wr_data bits 31:0 into bits 63:32 of the entry and leaves bits 31:0 unchanged.
- R4: A read of kind 0 returns entry bits 31:0, and a read of kind 1 returns entry bits 63:32. Both appear on rd_data bits 31:0 with bits 63:32 zero, and rd_err stays low.
- R5: In wide mode (wide_mode=1), a kind 2 (double) write stores all 64 data bits in the addressed entry at any index, and a kind 2 read returns all 64 bits.
- R6: In narrow mode, a kind 2 access at an even index i maps data bits 31:0 to bits 31:0 of entry i and data bits 63:32 to bits 31:0 of entry i+1. Bits 63:32 of both entries are left untouched. A read assembles the same pair.
- R7: In narrow mode, a kind 2 access at an odd index raises the port's error output in the same cycle. A write in that case changes nothing. A read in that case returns zero.
- R8: When several write ports hit the same half of the same entry in one cycle, the lowest-numbered port decides that half. A half that the lowest port does not touch takes the value from the next port that does.
- R9: Kind 3 is a no-op: it writes nothing, reads as zero and raises no error.
- R10: A write becomes visible on the read ports right after the clock edge that takes it. Reads are combinational and have no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wide_mode | input | 1 | 1: one double per entry; 0: doubles on even/odd pairs |
| wr_en | input | NUM_WR | Write enable per port |
| wr_idx | input | NUM_WR x IDX_W | Write entry index per port |
| wr_kind | input | NUM_WR x 2 | Write kind: 0 low word, 1 high word, 2 double, 3 none |
| wr_data | input | NUM_WR x 64 | Write data; word kinds use bits 31:0 |
| wr_err | output | NUM_WR | Odd-index double write in narrow mode |
| rd_idx | input | NUM_RD x IDX_W | Read entry index per port |
| rd_kind | input | NUM_RD x 2 | Read kind, same encoding as writes |
| rd_data | output | NUM_RD x 64 | Read data |
| rd_err | output | NUM_RD | Odd-index double read in narrow mode |

## Verification
The bench builds the bank with 8 entries, 32-bit words, two write ports and two read ports. With only 8 entries, random traffic makes both write ports land on the same entry often, so the per-half priority rules of R8 get exercised across every pairing of kinds. The top even pair (entries 6 and 7) and the odd-index error case are also reached many times. Both modes are run, with a reset between them.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  localparam logic [1:0] KIND_LO  = 2'd0;
  localparam logic [1:0] KIND_HI  = 2'd1;
  localparam logic [1:0] KIND_DBL = 2'd2;
  localparam logic [1:0] KIND_NOP = 2'd3;
endpackage

// File: rtl/fpr_wr_decode.sv
// Turns one write port into per-entry, per-half enables.
module fpr_wr_decode
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic                wide_mode,
  input  logic                en,
  input  logic [IDX_W-1:0]    idx,
  input  logic [1:0]          kind,
  input  logic [2*WORD_W-1:0] data,
  output logic [NUM_REGS-1:0] lo_en,
  output logic [NUM_REGS-1:0] lo_up,
  output logic [NUM_REGS-1:0] hi_en,
  output logic [WORD_W-1:0]   hi_val,
  output logic                err
);
  logic is_lo, is_hi, is_dbl, dbl_ok, pair_w;

  assign is_lo  = en && (kind == KIND_LO);
  assign is_hi  = en && (kind == KIND_HI);
  assign is_dbl = en && (kind == KIND_DBL);
  assign dbl_ok = is_dbl && (wide_mode || !idx[0]);
  assign pair_w = is_dbl && !wide_mode && !idx[0];
  assign err    = is_dbl && !wide_mode && idx[0];

  always_comb begin
    hi_val = '0;
    if (is_hi)       hi_val = data[WORD_W-1:0];
    else if (is_dbl) hi_val = data[2*WORD_W-1:WORD_W];
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_ent
    logic hit, partner;
    assign hit     = (idx == IDX_W'(r));
    assign partner = pair_w && (({1'b0, idx} + 1'b1) == (IDX_W+1)'(r));
    assign lo_en[r] = (hit && (is_lo || dbl_ok)) || partner;
    assign lo_up[r] = partner;
    assign hi_en[r] = hit && (is_lo || is_hi || (is_dbl && wide_mode));
  end
endmodule

// File: rtl/fpr_rd_port.sv
// One combinational read port.
module fpr_rd_port
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DW      = 2*WORD_W
) (
  input  logic                         wide_mode,
  input  logic [NUM_REGS-1:0][DW-1:0]  mem,
  input  logic [IDX_W-1:0]             idx,
  input  logic [1:0]                   kind,
  output logic [DW-1:0]                data,
  output logic                         err
);
  logic [IDX_W-1:0] idx_odd;
  logic             in_rng, odd_rng;

  assign idx_odd = idx | IDX_W'(1);
  assign in_rng  = (int'(idx) < NUM_REGS);
  assign odd_rng = (int'(idx_odd) < NUM_REGS);

  always_comb begin
    data = '0;
    err  = 1'b0;
    if (in_rng) begin
      unique case (kind)
        KIND_LO:  data = {{WORD_W{1'b0}}, mem[idx][WORD_W-1:0]};
        KIND_HI:  data = {{WORD_W{1'b0}}, mem[idx][DW-1:WORD_W]};
        KIND_DBL: begin
          if (wide_mode)   data = mem[idx];
          else if (idx[0]) err  = 1'b1;
          else if (odd_rng)
            data = {mem[idx_odd][WORD_W-1:0], mem[idx][WORD_W-1:0]};
        end
        default:  data = '0;
      endcase
    end
  end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 32,
  parameter int NUM_WR   = 2,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DW      = 2*WORD_W
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wide_mode,
  input  logic [NUM_WR-1:0]             wr_en,
  input  logic [NUM_WR-1:0][IDX_W-1:0]  wr_idx,
  input  logic [NUM_WR-1:0][1:0]        wr_kind,
  input  logic [NUM_WR-1:0][DW-1:0]     wr_data,
  output logic [NUM_WR-1:0]             wr_err,
  input  logic [NUM_RD-1:0][IDX_W-1:0]  rd_idx,
  input  logic [NUM_RD-1:0][1:0]        rd_kind,
  output logic [NUM_RD-1:0][DW-1:0]     rd_data,
  output logic [NUM_RD-1:0]             rd_err
);
  logic [NUM_REGS-1:0][DW-1:0]     mem;
  logic [NUM_WR-1:0][NUM_REGS-1:0] lo_en, lo_up, hi_en;
  logic [NUM_WR-1:0][WORD_W-1:0]   hi_val;

  for (genvar p = 0; p < NUM_WR; p++) begin : g_wr
    fpr_wr_decode #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_dec (
      .wide_mode (wide_mode),
      .en        (wr_en[p]),
      .idx       (wr_idx[p]),
      .kind      (wr_kind[p]),
      .data      (wr_data[p]),
      .lo_en     (lo_en[p]),
      .lo_up     (lo_up[p]),
      .hi_en     (hi_en[p]),
      .hi_val    (hi_val[p]),
      .err       (wr_err[p])
    );
  end

  // Storage: apply ports from highest to lowest so port 0 lands last.
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    logic [WORD_W-1:0] lo_nx, hi_nx;
    always_comb begin
      lo_nx = mem[r][WORD_W-1:0];
      hi_nx = mem[r][DW-1:WORD_W];
      for (int p = NUM_WR-1; p >= 0; p--) begin
        if (lo_en[p][r])
          lo_nx = lo_up[p][r] ? wr_data[p][DW-1:WORD_W] : wr_data[p][WORD_W-1:0];
        if (hi_en[p][r])
          hi_nx = hi_val[p];
      end
    end
    always_ff @(posedge clk) begin
      if (!rst_n) mem[r] <= '0;
      else        mem[r] <= {hi_nx, lo_nx};
    end
  end

  for (genvar q = 0; q < NUM_RD; q++) begin : g_rd
    fpr_rd_port #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_rd (
      .wide_mode (wide_mode),
      .mem       (mem),
      .idx       (rd_idx[q]),
      .kind      (rd_kind[q]),
      .data      (rd_data[q]),
      .err       (rd_err[q])
    );
  end
endmodule

// File: rtl/fpr_bank_chk.sv
module fpr_bank_chk
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = 32,
  parameter int WORD_W   = 32,
  parameter int NUM_WR   = 2,
  parameter int NUM_RD   = 2,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DW      = 2*WORD_W
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          wide_mode,
  input logic [NUM_WR-1:0]             wr_en,
  input logic [NUM_WR-1:0][IDX_W-1:0]  wr_idx,
  input logic [NUM_WR-1:0][1:0]        wr_kind,
  input logic [NUM_WR-1:0][DW-1:0]     wr_data,
  input logic [NUM_WR-1:0]             wr_err,
  input logic [NUM_RD-1:0][DW-1:0]     rd_data,
  input logic [NUM_RD-1:0]             rd_err,
  input logic [NUM_REGS-1:0][DW-1:0]   mem
);
  logic solo0;
  assign solo0 = (wr_en == NUM_WR'(1));

  assert_lo_clears_hi_R2: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && wr_kind[0] == KIND_LO |=> mem[$past(wr_idx[0])][DW-1:WORD_W] == '0);

  assert_hi_keeps_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && wr_kind[0] == KIND_HI |=>
      mem[$past(wr_idx[0])][WORD_W-1:0] == $past(mem[wr_idx[0]][WORD_W-1:0]));

  assert_pair_keeps_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && !wide_mode && wr_kind[0] == KIND_DBL && !wr_idx[0][0] |=>
      mem[$past(wr_idx[0]) | IDX_W'(1)][DW-1:WORD_W] ==
      $past(mem[wr_idx[0] | IDX_W'(1)][DW-1:WORD_W]));

  assert_odd_dbl_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    solo0 && wr_err[0] |=> mem == $past(mem));

  assert_port0_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wide_mode && wr_en[0] && wr_en[1] && wr_kind[0] == KIND_DBL &&
    wr_kind[1] == KIND_DBL && wr_idx[0] == wr_idx[1] |=>
      mem[$past(wr_idx[0])] == $past(wr_data[0]));

  assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en == '0 |=> mem == $past(mem));

  for (genvar q = 0; q < NUM_RD; q++) begin : g_rdchk
    assert_err_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err[q] |-> rd_data[q] == '0);
  end
endmodule

bind fpr_bank fpr_bank_chk #(
  .NUM_REGS(NUM_REGS), .WORD_W(WORD_W), .NUM_WR(NUM_WR), .NUM_RD(NUM_RD)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode), .wr_en(wr_en),
  .wr_idx(wr_idx), .wr_kind(wr_kind), .wr_data(wr_data), .wr_err(wr_err),
  .rd_data(rd_data), .rd_err(rd_err), .mem(mem)
);

// File: tb/fpr_bank_bench.sv
module fpr_bank_bench;
  localparam int CLK_P = 10;
  localparam int NREG  = 8;
  localparam int WW    = 32;
  localparam int IW    = $clog2(NREG);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wide_mode = 1'b1;
  logic [1:0]         wr_en = '0;
  logic [1:0][IW-1:0] wr_idx = '0;
  logic [1:0][1:0]    wr_kind = '0;
  logic [1:0][63:0]   wr_data = '0;
  logic [1:0]         wr_err;
  logic [1:0][IW-1:0] rd_idx = '0;
  logic [1:0][1:0]    rd_kind = '0;
  logic [1:0][63:0]   rd_data;
  logic [1:0]         rd_err;

  int total = 0;
  int bad = 0;
  logic [63:0] refm [NREG];

  always #(CLK_P/2) clk = ~clk;

  fpr_bank #(.NUM_REGS(NREG), .WORD_W(WW), .NUM_WR(2), .NUM_RD(2)) u_fpr_bank (
    .clk(clk), .rst_n(rst_n), .wide_mode(wide_mode),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind), .wr_data(wr_data),
    .wr_err(wr_err), .rd_idx(rd_idx), .rd_kind(rd_kind),
    .rd_data(rd_data), .rd_err(rd_err)
  );

  function automatic logic [64:0] exp_rd(int idx, int kind);
    case (kind)
      0: return {33'b0, refm[idx][31:0]};
      1: return {33'b0, refm[idx][63:32]};
      2: begin
        if (wide_mode) return {1'b0, refm[idx]};
        if (idx % 2 == 1) return {1'b1, 64'b0};
        return {1'b0, refm[idx+1][31:0], refm[idx][31:0]};
      end
      default: return 65'b0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [64:0] act, logic [64:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic apply_model();
    for (int p = 1; p >= 0; p--) begin
      if (wr_en[p]) begin
        int i;
        i = int'(wr_idx[p]);
        case (wr_kind[p])
          2'd0: refm[i] = {32'b0, wr_data[p][31:0]};
          2'd1: refm[i][63:32] = wr_data[p][31:0];
          2'd2: begin
            if (wide_mode) refm[i] = wr_data[p];
            else if (i % 2 == 0) begin
              refm[i][31:0]   = wr_data[p][31:0];
              refm[i+1][31:0] = wr_data[p][63:32];
            end
          end
          default: ;
        endcase
      end
    end
  endtask

  // Compare all outputs, then let one edge pass and update the model.
  task automatic step(string tag);
    #1;
    for (int q = 0; q < 2; q++) begin
      chk(tag, "rd", {rd_err[q], rd_data[q]}, exp_rd(int'(rd_idx[q]), int'(rd_kind[q])));
      chk(tag, "wr_err", {64'b0, wr_err[q]},
          {64'b0, wr_en[q] && wr_kind[q] == 2'd2 && !wide_mode && wr_idx[q][0]});
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) refm[i] = '0;
    end else begin
      apply_model();
    end
    @(negedge clk);
  endtask

  task automatic set_w(int p, logic en, int idx, int kind, logic [63:0] d);
    wr_en[p] = en; wr_idx[p] = IW'(idx); wr_kind[p] = 2'(kind); wr_data[p] = d;
  endtask

  task automatic set_r(int q, int idx, int kind);
    rd_idx[q] = IW'(idx); rd_kind[q] = 2'(kind);
  endtask

  task automatic idle();
    wr_en = '0;
  endtask

  task automatic do_reset(logic mode);
    @(negedge clk);
    idle();
    wide_mode = mode;
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    for (int i = 0; i < NREG; i++) refm[i] = '0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NREG; i++) begin
      set_r(0, i, 0); set_r(1, i, 1);
      step("R1");
    end
  endtask

  task automatic random_run(int n);
    for (int k = 0; k < n; k++) begin
      for (int p = 0; p < 2; p++)
        set_w(p, 1'($urandom), int'($urandom % NREG), int'($urandom % 4),
              {$urandom, $urandom});
      for (int q = 0; q < 2; q++)
        set_r(q, int'($urandom % NREG), int'($urandom % 4));
      step("R10");
    end
    idle();
  endtask

  initial begin
    #(CLK_P * 200000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NREG; i++) refm[i] = '0;

    // ---------------- wide mode ----------------
    do_reset(1'b1);
    set_w(0, 1, 3, 2, 64'hFFFF_FFFF_FFFF_FFFF); set_r(0, 3, 2); set_r(1, 3, 1);
    step("R5");
    set_w(0, 1, 3, 0, 64'hAAAA_BBBB_1111_2222);
    step("R5");
    idle();
    step("R2");
    set_w(0, 1, 3, 1, 64'h0000_0000_CAFE_F00D);
    step("R2");
    idle(); set_r(1, 3, 0);
    step("R3");
    set_r(1, 3, 1);
    step("R4");
    set_w(0, 1, 7, 2, 64'h0123_4567_89AB_CDEF); set_r(0, 7, 2);
    step("R10");
    idle();
    step("R5");
    // collision: port 0 high word, port 1 low word on entry 2
    set_w(0, 1, 2, 1, 64'h0000_0000_DDDD_0000);
    set_w(1, 1, 2, 0, 64'h0000_0000_0000_EEEE); set_r(0, 2, 2);
    step("R8");
    idle();
    step("R8");
    // collision: both doubles on entry 5
    set_w(0, 1, 5, 2, 64'h5050_5050_0505_0505);
    set_w(1, 1, 5, 2, 64'h9999_9999_9999_9999); set_r(0, 5, 2);
    step("R8");
    idle();
    step("R8");
    // kind 3 is a no-op
    set_w(0, 1, 7, 3, 64'hFFFF_FFFF_FFFF_FFFF); set_r(0, 7, 3); set_r(1, 7, 1);
    step("R9");
    idle(); set_r(0, 7, 2);
    step("R9");
    random_run(400);

    // ---------------- narrow mode ----------------
    do_reset(1'b0);
    set_w(0, 1, 4, 1, 64'h0000_0000_4444_4444);
    set_w(1, 1, 5, 1, 64'h0000_0000_5555_5555);
    step("R3");
    idle();
    set_w(0, 1, 4, 2, 64'h1234_5678_9ABC_DEF0); set_r(0, 4, 1); set_r(1, 5, 1);
    step("R6");
    idle();
    step("R6");
    set_r(0, 4, 2); set_r(1, 5, 0);
    step("R6");
    // odd double: error, no write
    set_w(0, 1, 5, 2, 64'hDEAD_BEEF_DEAD_BEEF); set_r(0, 5, 2); set_r(1, 5, 0);
    step("R7");
    idle(); set_r(0, 4, 2);
    step("R7");
    set_w(0, 1, 6, 0, 64'h7777_7777_0BAD_F00D); set_r(0, 6, 1);
    step("R2");
    idle();
    step("R2");
    random_run(400);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule